// File: doc/BRIEF.md
# Bidirectional Register-Mapped GPIO Port

This block is an 8-bit general-purpose I/O port on a simple CPU bus. The CPU reaches three byte-wide registers at fixed zero-page addresses: the output latch, a direction mask and a pull-up enable mask. Each pin is driven from the latch when its direction bit is 1. When its direction bit is 0 the pin is left floating (output enable low), and its level is sampled through a two-flop synchronizer.

A read of the data address returns a merged value. Output-mode bits return the latch, so a disturbed pin voltage does not corrupt what software reads back. Input-mode bits return the synchronized pin level. A write always lands in the latch, whatever the direction, and the stored value appears on a pin once that pin is turned to output.

While the CPU sits in a low-power mode, the port watches the input-mode pins that have their pull-up enabled, which is a key-matrix arrangement. Any such pin pulled low raises a wake request. The request is held until the low-power flag drops.

Top module: `gpio_port`

## Requirements
- R1: Writes to address 0xC0 load the output latch, writes to 0xC1 load the direction mask, and writes to 0xC2 load the pull-up mask. A write to any other address changes nothing, and a read from any other address returns 0.
- R2: Direction bit 1 makes a pin an output and bit 0 makes it an input. pin_oe_o equals the direction mask, and a read of 0xC1 returns it.
- R3: pin_o carries the output latch on every bit, so every output-mode pin drives its latched value.
- R4: A read of 0xC0 returns the latch value for output-mode bits, regardless of the pin level.
- R5: A read of 0xC0 returns the pin level for input-mode bits. A pin change becomes visible in the read data after the second rising clock edge that follows it.
- R6: A write to 0xC0 updates the latch for input-mode bits too, and their output enable stays low. When such a bit is later switched to output, it drives the stored value.
- R7: After reset the direction mask, the latch and the pull-up mask are all 0, and wake_o is 0.
- R8: Pull-up enables are set one bit at a time through 0xC2, and a read of 0xC2 returns the mask. pull_en_o is asserted only for bits that are both enabled and in input mode.
- R9: While lp_mode_i is 1, wake_o rises on the third rising edge after an input-mode pin whose pull-up is enabled goes low. Pins in output mode and pins with the pull-up disabled never raise it, and nothing raises it while lp_mode_i is 0.
- R10: Once wake_o is set it stays set while lp_mode_i is 1, even after the pin returns high. It clears on the first rising edge with lp_mode_i at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Bus address |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| lp_mode_i | input | 1 | CPU is in stop or wait mode |
| pin_i | input | 8 | Sampled pad levels |
| pin_o | output | 8 | Pad output values |
| pin_oe_o | output | 8 | Pad output enables |
| pull_en_o | output | 8 | Pull-up enables per pad |
| wake_o | output | 1 | Key-input wake request |

## Verification
The bench drives a disturbed pin under an output-mode bit and checks the read-back. A design that returned the pad would read the wrong value. It writes data while bits are inputs and then flips them to outputs: a design that dropped the write, or drove the pad early, shows the wrong pin_o or pin_oe_o. It checks the wake request on the exact third edge after a key press, checks that it stays set after release, and checks that output-mode, unpulled and non-low-power presses are all ignored. A design that was level-sensitive, or that skipped the masks, either drops the request or raises a false one. Writes to the neighbouring unmapped addresses then confirm that no register aliases.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_PULL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  // reset to idle-high so a pulled-up pad does not look pressed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NGRP  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  reg_sel_e         sel_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [NGRP-1:0]  pull_o
);
  logic [WIDTH-1:0] latch_q, dir_q;
  logic [NGRP-1:0]  pull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      dir_q   <= '0;
      pull_q  <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_DATA: latch_q <= wdata_i;
        SEL_DIR:  dir_q   <= wdata_i;
        SEL_PULL: pull_q  <= wdata_i[NGRP-1:0];
        default: ;
      endcase
    end
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;
  assign pull_o  = pull_q;

  // latch loads on every data write, input-mode bits included
  p_latch_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_DATA) |=> (latch_q == $past(wdata_i)));

  p_dir_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_i == SEL_DIR) |=> $stable(dir_q));

  p_pull_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_i == SEL_PULL) |=> $stable(pull_q));
endmodule

// File: rtl/gpio_wake.sv
module gpio_wake #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lp_i,
  input  logic [WIDTH-1:0] key_i,
  output logic             wake_o
);
  logic wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wake_q <= 1'b0;
    else if (!lp_i)     wake_q <= 1'b0;
    else if (|key_i)    wake_q <= 1'b1;
  end

  assign wake_o = wake_q;

  p_wake_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_q) |-> ($past(lp_i) && $past(|key_i)));

  p_wake_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_i && wake_q) |=> wake_q);

  p_wake_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lp_i |=> !wake_q);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int             WIDTH      = 8,
  parameter int             ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'hC0,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'hC1,
  parameter logic [ADDR_W-1:0] PULL_ADDR = 8'hC2,
  parameter int             PULL_GROUP = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic              lp_mode_i,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o,
  output logic [WIDTH-1:0]  pull_en_o,
  output logic              wake_o
);
  localparam int NGRP = WIDTH / PULL_GROUP;

  reg_sel_e         sel;
  logic [WIDTH-1:0] latch, dir, pin_sync, pull_bits, pull_rd, key;
  logic [NGRP-1:0]  pull_grp;

  always_comb begin
    if      (addr_i == DATA_ADDR) sel = SEL_DATA;
    else if (addr_i == DIR_ADDR)  sel = SEL_DIR;
    else if (addr_i == PULL_ADDR) sel = SEL_PULL;
    else                          sel = SEL_NONE;
  end

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .NGRP(NGRP)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .we_i   (we_i),
    .wdata_i(wdata_i),
    .latch_o(latch),
    .dir_o  (dir),
    .pull_o (pull_grp)
  );

  // one pull-up bit per group of PULL_GROUP pins
  for (genvar i = 0; i < WIDTH; i++) begin : g_pull
    assign pull_bits[i] = pull_grp[i / PULL_GROUP];
  end

  always_comb begin
    pull_rd = '0;
    pull_rd[NGRP-1:0] = pull_grp;
  end

  assign key = ~dir & pull_bits & ~pin_sync;

  gpio_wake #(.WIDTH(WIDTH)) u_wake (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lp_i  (lp_mode_i),
    .key_i (key),
    .wake_o(wake_o)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata_o = (dir & latch) | (~dir & pin_sync);
      SEL_DIR:  rdata_o = dir;
      SEL_PULL: rdata_o = pull_rd;
      default:  rdata_o = '0;
    endcase
  end

  assign pin_o     = latch;
  assign pin_oe_o  = dir;
  assign pull_en_o = pull_bits & ~dir;

  p_pull_inputs_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_en_o & pin_oe_o) == '0);

  p_out_bits_latched_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_DATA) |-> ((rdata_o & pin_oe_o) == (pin_o & pin_oe_o)));

  p_unmapped_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_NONE) |-> (rdata_o == '0));
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       lp_mode_i = 1'b0;
  logic [7:0] pin_i = 8'hFF;
  logic [7:0] pin_o, pin_oe_o, pull_en_o;
  logic       wake_o;

  int total = 0;
  int bad = 0;

  logic [7:0] m_lat = 8'h00, m_dir = 8'h00, m_pull = 8'h00;

  gpio_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .lp_mode_i(lp_mode_i),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .pull_en_o(pull_en_o), .wake_o(wake_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] exp_data(logic [7:0] lat, logic [7:0] dir, logic [7:0] pin);
    return (dir & lat) | (~dir & pin);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    if (a == 8'hC0) m_lat = d;
    if (a == 8'hC1) m_dir = d;
    if (a == 8'hC2) m_pull = d;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #5 d = rdata_o;
  endtask

  task automatic set_pins(logic [7:0] v);
    @(negedge clk_i);
    pin_i = v;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic check_all();
    logic [7:0] d;
    rd(8'hC0, d); chk("R4/R5 data read", d, exp_data(m_lat, m_dir, pin_i));
    rd(8'hC1, d); chk("R2 dir read", d, m_dir);
    rd(8'hC2, d); chk("R8 pull read", d, m_pull);
    chk("R2 oe", pin_oe_o, m_dir);
    chk("R3 pin_o", pin_o, m_lat);
    chk("R8 pull_en", pull_en_o, m_pull & ~m_dir);
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog act=00 exp=01");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R7 reset state
    chk("R7 oe", pin_oe_o, 8'h00);
    chk("R7 pin_o", pin_o, 8'h00);
    chk("R7 pull", pull_en_o, 8'h00);
    chk("R7 wake", {7'd0, wake_o}, 8'h00);
    rd(8'hC1, d); chk("R7 dir", d, 8'h00);

    // R6 write while input, then flip to output
    wr(8'hC0, 8'h5A);
    chk("R6 oe stays low", pin_oe_o, 8'h00);
    rd(8'hC0, d); chk("R6 read shows pins", d, pin_i);
    wr(8'hC1, 8'h0F);
    chk("R6 stored value drives", pin_o & pin_oe_o, 8'h0A);

    // R4 disturbed pin under output bits
    set_pins(8'h00);
    rd(8'hC0, d); chk("R4 latch not pin", d, 8'h0A);

    // R5 two-edge latency
    wr(8'hC1, 8'h00);
    @(negedge clk_i); pin_i = 8'hA5;
    @(negedge clk_i); addr_i = 8'hC0; #5 chk("R5 one edge old", rdata_o, 8'h00);
    @(negedge clk_i); #5 chk("R5 two edges new", rdata_o, 8'hA5);

    // R1 unmapped neighbours
    wr(8'hC3, 8'hFF);
    wr(8'hBF, 8'hFF);
    rd(8'hC3, d); chk("R1 unmapped read", d, 8'h00);
    check_all();

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 4);
      logic [7:0] v = 8'($urandom());
      case (op)
        0: wr(8'hC0, v);
        1: wr(8'hC1, v);
        2: wr(8'hC2, v);
        3: set_pins(v);
        default: wr(8'($urandom_range(8'hBE, 8'hC4)), v);
      endcase
      check_all();
    end

    // R9/R10 wake
    wr(8'hC1, 8'h02);
    wr(8'hC2, 8'h03);
    set_pins(8'hFF);
    @(negedge clk_i); pin_i = 8'hFE;
    repeat (3) @(negedge clk_i);
    chk("R9 no wake when not low-power", {7'd0, wake_o}, 8'h00);
    set_pins(8'hFF);
    lp_mode_i = 1'b1;
    @(negedge clk_i); pin_i = 8'hFD; // output-mode bit
    repeat (4) @(negedge clk_i);
    chk("R9 output pin ignored", {7'd0, wake_o}, 8'h00);
    pin_i = 8'hFB; // pull disabled
    repeat (4) @(negedge clk_i);
    chk("R9 unpulled pin ignored", {7'd0, wake_o}, 8'h00);
    pin_i = 8'hFE;
    repeat (2) @(negedge clk_i);
    chk("R9 not before third edge", {7'd0, wake_o}, 8'h00);
    @(negedge clk_i);
    chk("R9 third edge", {7'd0, wake_o}, 8'h01);
    pin_i = 8'hFF;
    repeat (4) @(negedge clk_i);
    chk("R10 sticky", {7'd0, wake_o}, 8'h01);
    lp_mode_i = 1'b0;
    @(negedge clk_i);
    chk("R10 clear", {7'd0, wake_o}, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule